// File: doc/BRIEF.md
# 100 Mb/s Twisted-Pair Transmit Coding Path with Raw Code Bypass

This block is the digital transmit half of a 100 Mb/s twisted-pair physical layer. It runs on a single 125 MHz symbol clock and asks its source for one 4-bit nibble every five clocks. Each nibble is turned into a 5-bit code group. Frame start and frame end delimiters are inserted around the data. The bits are sent most significant first, whitened by an 11-bit scrambler, and the result drives a three-level MLT-3 symbol output.

A raw mode lets the source supply already-scrambled 5-bit code groups directly. This mode skips the nibble mapping, the framing and the scrambler, and it ignores the frame-enable input. It is selected by either a pin or a configuration bit.

A matching receive demapper listens to the block's own line output. It undoes MLT-3 and the scrambler, regroups the bits, and presents nibbles with valid and error flags. This provides a loopback view of the transmit path.

Top module: `mlt3TxPcs`

## Requirements
- R1: While `rstN` is low, `lineSym`, `rxDv`, `rxEr`, `rxD` and `nibbleReq` are all 0. The scrambler state is set to 11'h7FF, and the code group in flight is IDLE.
- R2: Inside a frame, a data nibble n is sent as its 5-bit group: 0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101.
- R3: Outside a frame, the group sent is IDLE (11111). `txEr` with `txEn` low has no effect on the line.
- R4: When `txEn` is seen high at a nibble boundary outside a frame, that nibble is replaced by J (11000). The next nibble is replaced by K (10001), whatever `txEn` is then.
- R5: The first nibble boundary in the data phase with `txEn` low sends T (01101). The next boundary sends R (00111), and the boundary after that starts idle again.
- R6: A data-phase nibble with both `txEn` and `txEr` high is sent as the error group 00100.
- R7: The scrambler shifts every clock. Its key bit is bit 10 XOR bit 8 of its state (x^11+x^9+1), and the key bit is shifted in at bit 0. The line bit is the code bit XOR the key bit. Code bits go out MSB first, one per clock.
- R8: `lineSym` (2'b00 = 0, 2'b01 = +1, 2'b11 = −1) steps through 0, +1, 0, −1 on each line bit of 1 and holds on a 0. The symbol after a clock edge reflects the bit of the clock before it.
- R9: If `bypassPin` or `bypassCfg` is high at a nibble boundary, the group is {`txEr`, `txD`} with `txEr` as MSB. It is sent without scrambling, any frame in progress is dropped, and `txEn` is ignored.
- R10: The demapper updates its outputs 6 clocks after the boundary edge that sampled a nibble, and holds them otherwise. J and K give `rxDv`=1 with `rxD`=0101. Data groups give their nibble with `rxDv`=1. Error groups give `rxDv`=1, `rxEr`=1, `rxD`=0. T, R and IDLE give all zeros.
- R11: In raw mode the demapper outputs the received unscrambled 5-bit group on {`rxEr`, `rxD`} and holds `rxDv` low.
- R12: `nibbleReq` is high for exactly one clock in every five, first in the fifth clock after reset. The inputs are sampled at the edge that ends that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz symbol clock |
| rstN | input | 1 | Active-low synchronous reset |
| txEn | input | 1 | Frame enable from the MAC |
| txEr | input | 1 | Error request; fifth code bit in raw mode |
| txD | input | 4 | Transmit nibble |
| bypassPin | input | 1 | Raw mode select, pin |
| bypassCfg | input | 1 | Raw mode select, configuration bit |
| nibbleReq | output | 1 | Inputs are sampled at the end of this clock |
| lineSym | output | 2 | MLT-3 symbol, two's complement |
| rxDv | output | 1 | Loopback receive data valid |
| rxEr | output | 1 | Loopback receive error; raw MSB in raw mode |
| rxD | output | 4 | Loopback receive nibble |

## Verification
The bench drives a frame that walks all sixteen nibble values, so a single wrong entry in the code table shows up as a diverging line symbol and a wrong looped-back nibble. It also covers a frame whose `txEn` lasts only one nibble: a design that dropped the mandatory K, or that let `txEn` end the frame early, would emit T too soon. Error nibbles in the data phase and `txEr` alone while idle separate a design that leaks errors into idle from one that honours them only in a frame. Raw mode is entered from both select inputs while `txEn` toggles. A design that kept scrambling, reordered the fifth bit or let `txEn` start a frame would corrupt the line stream or raise `rxDv`.

// File: rtl/mlt3TxPcsPkg.sv
package mlt3TxPcsPkg;

  localparam int NIB_W = 4;
  localparam int CG_W  = NIB_W + 1;

  localparam logic [CG_W-1:0]  CG_IDLE = 5'b11111;
  localparam logic [CG_W-1:0]  CG_J    = 5'b11000;
  localparam logic [CG_W-1:0]  CG_K    = 5'b10001;
  localparam logic [CG_W-1:0]  CG_T    = 5'b01101;
  localparam logic [CG_W-1:0]  CG_R    = 5'b00111;
  localparam logic [CG_W-1:0]  CG_H    = 5'b00100;
  localparam logic [NIB_W-1:0] PREAMBLE_NIB = 4'b0101;

  typedef enum logic [2:0] {
    SEL_IDLE, SEL_J, SEL_K, SEL_T, SEL_R, SEL_DATA, SEL_ERR, SEL_RAW
  } codeSel_e;

  typedef struct packed {
    logic     load;
    codeSel_e sel;
  } txStrobe_t;

  typedef struct packed {
    logic             hit;
    logic [NIB_W-1:0] nib;
  } demap_t;

  function automatic logic [CG_W-1:0] mapNibble(input logic [NIB_W-1:0] nib);
    logic [CG_W-1:0] cg;
    case (nib)
      4'h0: cg = 5'b11110;
      4'h1: cg = 5'b01001;
      4'h2: cg = 5'b10100;
      4'h3: cg = 5'b10101;
      4'h4: cg = 5'b01010;
      4'h5: cg = 5'b01011;
      4'h6: cg = 5'b01110;
      4'h7: cg = 5'b01111;
      4'h8: cg = 5'b10010;
      4'h9: cg = 5'b10011;
      4'hA: cg = 5'b10110;
      4'hB: cg = 5'b10111;
      4'hC: cg = 5'b11010;
      4'hD: cg = 5'b11011;
      4'hE: cg = 5'b11100;
      default: cg = 5'b11101;
    endcase
    return cg;
  endfunction

  function automatic demap_t unmapCode(input logic [CG_W-1:0] cg);
    demap_t r;
    r = '0;
    for (int i = 0; i < (1 << NIB_W); i++) begin
      if (mapNibble(NIB_W'(i)) == cg) begin
        r.hit = 1'b1;
        r.nib = NIB_W'(i);
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/txPcsCtrl.sv
module txPcsCtrl
  import mlt3TxPcsPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      txEn,
  input  logic      txEr,
  input  logic      bypass,
  output txStrobe_t strobe,
  output logic      nibbleReq,
  output logic      groupEnd
);

  localparam int PH_W = $clog2(CG_W);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(CG_W - 1);

  typedef enum logic [1:0] {F_IDLE, F_K, F_DATA, F_R} frame_e;

  logic [PH_W-1:0] phase;
  frame_e          frame, frameNext;
  codeSel_e        sel;

  always_ff @(posedge clk) begin
    if (!rstN) phase <= '0;
    else if (phase == LAST_PH) phase <= '0;
    else phase <= phase + 1'b1;
  end

  assign nibbleReq = (phase == LAST_PH);
  assign groupEnd  = (phase == '0);

  always_comb begin
    sel       = SEL_IDLE;
    frameNext = frame;
    if (bypass) begin
      sel       = SEL_RAW;
      frameNext = F_IDLE;
    end else begin
      unique case (frame)
        F_IDLE: if (txEn) begin
          sel       = SEL_J;
          frameNext = F_K;
        end
        F_K: begin
          sel       = SEL_K;
          frameNext = F_DATA;
        end
        F_DATA: if (txEn) begin
          sel = txEr ? SEL_ERR : SEL_DATA;
        end else begin
          sel       = SEL_T;
          frameNext = F_R;
        end
        default: begin
          sel       = SEL_R;
          frameNext = F_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) frame <= F_IDLE;
    else if (nibbleReq) frame <= frameNext;
  end

  assign strobe.load = nibbleReq;
  assign strobe.sel  = sel;

endmodule

// File: rtl/txPcsDatapath.sv
module txPcsDatapath
  import mlt3TxPcsPkg::*;
#(
  parameter int LFSR_W   = 11,
  parameter int LFSR_TAP = 9,
  parameter logic [LFSR_W-1:0] LFSR_SEED = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  txStrobe_t        strobe,
  input  logic             txEr,
  input  logic [NIB_W-1:0] txD,
  output logic [1:0]       lineSym
);

  logic [CG_W-1:0]   groupNext, shiftReg;
  logic              rawGroup;
  logic [LFSR_W-1:0] lfsr;
  logic              keyBit, codeBit, lineBit;
  logic [1:0]        mltIdx;

  always_comb begin
    unique case (strobe.sel)
      SEL_J:    groupNext = CG_J;
      SEL_K:    groupNext = CG_K;
      SEL_T:    groupNext = CG_T;
      SEL_R:    groupNext = CG_R;
      SEL_DATA: groupNext = mapNibble(txD);
      SEL_ERR:  groupNext = CG_H;
      SEL_RAW:  groupNext = {txEr, txD};
      default:  groupNext = CG_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= CG_IDLE;
      rawGroup <= 1'b0;
    end else if (strobe.load) begin
      shiftReg <= groupNext;
      rawGroup <= (strobe.sel == SEL_RAW);
    end else begin
      shiftReg <= {shiftReg[CG_W-2:0], 1'b0};
    end
  end

  assign keyBit  = lfsr[LFSR_W-1] ^ lfsr[LFSR_TAP-1];
  assign codeBit = shiftReg[CG_W-1];
  assign lineBit = rawGroup ? codeBit : (codeBit ^ keyBit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lfsr   <= LFSR_SEED;
      mltIdx <= 2'd0;
    end else begin
      lfsr   <= {lfsr[LFSR_W-2:0], keyBit};
      mltIdx <= mltIdx + {1'b0, lineBit};
    end
  end

  always_comb begin
    unique case (mltIdx)
      2'd1:    lineSym = 2'b01;
      2'd3:    lineSym = 2'b11;
      default: lineSym = 2'b00;
    endcase
  end

endmodule

// File: rtl/rxPcsDemap.sv
module rxPcsDemap
  import mlt3TxPcsPkg::*;
#(
  parameter int LFSR_W   = 11,
  parameter int LFSR_TAP = 9,
  parameter logic [LFSR_W-1:0] LFSR_SEED = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       lineSym,
  input  logic             groupEnd,
  input  logic             bypass,
  output logic             rxDv,
  output logic             rxEr,
  output logic [NIB_W-1:0] rxD
);

  logic [1:0]        prevSym;
  logic              started;
  logic [LFSR_W-1:0] lfsr;
  logic              keyBit, nrzBit, plainBit;
  logic [CG_W-2:0]   collect;
  logic [CG_W-1:0]   group;
  logic              inFrame;
  demap_t            dm;

  assign nrzBit   = (lineSym != prevSym);
  assign keyBit   = lfsr[LFSR_W-1] ^ lfsr[LFSR_TAP-1];
  assign plainBit = bypass ? nrzBit : (nrzBit ^ keyBit);
  assign group    = {collect, plainBit};
  assign dm       = unmapCode(group);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevSym <= 2'b00;
      started <= 1'b0;
      lfsr    <= LFSR_SEED;
      collect <= '0;
    end else begin
      prevSym <= lineSym;
      started <= 1'b1;
      if (started) lfsr <= {lfsr[LFSR_W-2:0], keyBit};
      collect <= {collect[CG_W-3:0], plainBit};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxDv    <= 1'b0;
      rxEr    <= 1'b0;
      rxD     <= '0;
      inFrame <= 1'b0;
    end else if (started && groupEnd) begin
      if (bypass) begin
        rxDv        <= 1'b0;
        {rxEr, rxD} <= group;
        inFrame     <= 1'b0;
      end else if (group == CG_J || group == CG_K) begin
        rxDv    <= 1'b1;
        rxEr    <= 1'b0;
        rxD     <= PREAMBLE_NIB;
        inFrame <= 1'b1;
      end else if (group == CG_T || group == CG_R || group == CG_IDLE) begin
        rxDv    <= 1'b0;
        rxEr    <= 1'b0;
        rxD     <= '0;
        inFrame <= 1'b0;
      end else if (dm.hit) begin
        rxDv <= inFrame;
        rxEr <= 1'b0;
        rxD  <= inFrame ? dm.nib : '0;
      end else begin
        rxDv <= inFrame;
        rxEr <= inFrame;
        rxD  <= '0;
      end
    end
  end

endmodule

// File: rtl/mlt3TxPcs.sv
module mlt3TxPcs
  import mlt3TxPcsPkg::*;
#(
  parameter int LFSR_W   = 11,
  parameter int LFSR_TAP = 9,
  parameter logic [LFSR_W-1:0] LFSR_SEED = '1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       txEn,
  input  logic       txEr,
  input  logic [3:0] txD,
  input  logic       bypassPin,
  input  logic       bypassCfg,
  output logic       nibbleReq,
  output logic [1:0] lineSym,
  output logic       rxDv,
  output logic       rxEr,
  output logic [3:0] rxD
);

  logic      bypass;
  logic      groupEnd;
  txStrobe_t strobe;

  assign bypass = bypassPin | bypassCfg;

  txPcsCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .txEn      (txEn),
    .txEr      (txEr),
    .bypass    (bypass),
    .strobe    (strobe),
    .nibbleReq (nibbleReq),
    .groupEnd  (groupEnd)
  );

  txPcsDatapath #(
    .LFSR_W    (LFSR_W),
    .LFSR_TAP  (LFSR_TAP),
    .LFSR_SEED (LFSR_SEED)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .txEr    (txEr),
    .txD     (txD),
    .lineSym (lineSym)
  );

  rxPcsDemap #(
    .LFSR_W    (LFSR_W),
    .LFSR_TAP  (LFSR_TAP),
    .LFSR_SEED (LFSR_SEED)
  ) u_rx (
    .clk      (clk),
    .rstN     (rstN),
    .lineSym  (lineSym),
    .groupEnd (groupEnd),
    .bypass   (bypass),
    .rxDv     (rxDv),
    .rxEr     (rxEr),
    .rxD      (rxD)
  );

endmodule

// File: rtl/mlt3TxPcsChecker.sv
module mlt3TxPcsChecker
  import mlt3TxPcsPkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       nibbleReq,
  input logic       bypassPin,
  input logic       bypassCfg,
  input logic [1:0] lineSym,
  input logic       rxDv,
  input logic       rxEr,
  input logic [3:0] rxD
);

  logic [2:0] gap;

  always_ff @(posedge clk) begin
    if (!rstN) gap <= '0;
    else if (nibbleReq) gap <= '0;
    else gap <= gap + 1'b1;
  end

  p_sym_legal_r8: assert property (@(posedge clk) disable iff (!rstN)
    lineSym != 2'b10);

  p_mlt_no_jump_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(($past(lineSym) == 2'b01 && lineSym == 2'b11) ||
      ($past(lineSym) == 2'b11 && lineSym == 2'b01)));

  p_req_period_r12: assert property (@(posedge clk) disable iff (!rstN)
    nibbleReq |-> (gap == 3'(CG_W - 1)));

  p_req_single_r12: assert property (@(posedge clk) disable iff (!rstN)
    nibbleReq |=> !nibbleReq);

  p_rx_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !$past(nibbleReq, 2) |-> ($stable(rxDv) && $stable(rxEr) && $stable(rxD)));

  p_raw_no_dv_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxDv) |-> !$past(bypassPin || bypassCfg));

endmodule

bind mlt3TxPcs mlt3TxPcsChecker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .nibbleReq (nibbleReq),
  .bypassPin (bypassPin),
  .bypassCfg (bypassCfg),
  .lineSym   (lineSym),
  .rxDv      (rxDv),
  .rxEr      (rxEr),
  .rxD       (rxD)
);

// File: tb/test_mlt3TxPcs.sv
module test_mlt3TxPcs;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rstN, txEn, txEr, bypassPin, bypassCfg;
  logic [3:0] txD;
  logic       nibbleReq, rxDv, rxEr;
  logic [1:0] lineSym;
  logic [3:0] rxD;

  mlt3TxPcs i_mlt3TxPcs (
    .clk(clk), .rstN(rstN), .txEn(txEn), .txEr(txEr), .txD(txD),
    .bypassPin(bypassPin), .bypassCfg(bypassCfg), .nibbleReq(nibbleReq),
    .lineSym(lineSym), .rxDv(rxDv), .rxEr(rxEr), .rxD(rxD)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  typedef struct {
    int    due;
    int    loadEdge;
    bit    dv;
    bit    er;
    bit [3:0] d;
    string tag;
  } rxExp_t;

  rxExp_t     rxQ[$];
  rxExp_t     ent;
  bit [10:0]  mLfsr;
  bit [4:0]   mGroup;
  int         mPhase, mLevel, mState, edgeCnt, modeEdge;
  bit         mRaw, prevMode, mode, b, k, sb;
  string      mTag;
  bit         expDv, expEr, expRxOk;
  bit [3:0]   expD;
  string      expTag;

  function automatic bit [4:0] enc(input bit [3:0] n);
    bit [4:0] t[16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                        5'b01010, 5'b01011, 5'b01110, 5'b01111,
                        5'b10010, 5'b10011, 5'b10110, 5'b10111,
                        5'b11010, 5'b11011, 5'b11100, 5'b11101};
    return t[n];
  endfunction

  function automatic bit [1:0] levelSym(input int idx);
    case (idx)
      1: return 2'b01;
      3: return 2'b11;
      default: return 2'b00;
    endcase
  endfunction

  task automatic pushRx(input bit dv, input bit er, input bit [3:0] d, input string tag);
    rxExp_t e;
    e.due = edgeCnt + 6; e.loadEdge = edgeCnt;
    e.dv = dv; e.er = er; e.d = d; e.tag = tag;
    rxQ.push_back(e);
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mLfsr = 11'h7FF; mGroup = 5'b11111; mPhase = 0; mLevel = 0;
      mState = 0; edgeCnt = 0; modeEdge = -100; mRaw = 0; prevMode = 0;
      mTag = "R1"; rxQ.delete();
      expDv = 0; expEr = 0; expD = 0; expRxOk = 1; expTag = "R1";
    end else begin
      edgeCnt++;
      b  = mGroup[4 - mPhase];
      k  = mLfsr[10] ^ mLfsr[8];
      sb = mRaw ? b : (b ^ k);
      if (sb) mLevel = (mLevel + 1) % 4;
      mLfsr = {mLfsr[9:0], k};
      mode = bypassPin | bypassCfg;
      if (mode != prevMode) begin modeEdge = edgeCnt; prevMode = mode; end
      if (mPhase == 4) begin
        if (mode) begin
          mGroup = {txEr, txD}; mRaw = 1; mState = 0; mTag = "R9";
          pushRx(0, txEr, txD, "R11");
        end else begin
          mRaw = 0;
          case (mState)
            0: if (txEn) begin
                 mGroup = 5'b11000; mState = 1; mTag = "R4"; pushRx(1, 0, 4'b0101, "R4");
               end else begin
                 mGroup = 5'b11111; mTag = "R3"; pushRx(0, 0, 0, "R3");
               end
            1: begin mGroup = 5'b10001; mState = 2; mTag = "R4"; pushRx(1, 0, 4'b0101, "R4"); end
            2: if (!txEn) begin
                 mGroup = 5'b01101; mState = 3; mTag = "R5"; pushRx(0, 0, 0, "R5");
               end else if (txEr) begin
                 mGroup = 5'b00100; mTag = "R6"; pushRx(1, 1, 0, "R6");
               end else begin
                 mGroup = enc(txD); mTag = "R2"; pushRx(1, 0, txD, "R2");
               end
            default: begin mGroup = 5'b00111; mState = 0; mTag = "R5"; pushRx(0, 0, 0, "R5"); end
          endcase
        end
      end
      mPhase = (mPhase + 1) % 5;
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      check(lineSym == levelSym(mLevel), {"R7 R8 ", mTag}, "lineSym",
            int'(lineSym), int'(levelSym(mLevel)));
      check(nibbleReq == (mPhase == 4), "R12", "nibbleReq",
            int'(nibbleReq), int'(mPhase == 4));
      while (rxQ.size() > 0 && rxQ[0].due <= edgeCnt) begin
        ent = rxQ.pop_front();
        expDv = ent.dv; expEr = ent.er; expD = ent.d; expTag = ent.tag;
        expRxOk = !(modeEdge > ent.loadEdge && modeEdge <= ent.due);
      end
      if (expRxOk) begin
        check(rxDv == expDv, {"R10 ", expTag}, "rxDv", int'(rxDv), int'(expDv));
        check(rxEr == expEr, {"R10 ", expTag}, "rxEr", int'(rxEr), int'(expEr));
        check(rxD == expD, {"R10 ", expTag}, "rxD", int'(rxD), int'(expD));
      end
    end
  end

  bit modePin = 0, modeCfg = 0;

  task automatic sendNib(input bit en, input bit er, input bit [3:0] d);
    @(negedge clk);
    while (!nibbleReq) @(negedge clk);
    txEn = en; txEr = er; txD = d;
    bypassPin = modePin; bypassCfg = modeCfg;
  endtask

  initial begin
    rstN = 0; txEn = 0; txEr = 0; txD = 0; bypassPin = 0; bypassCfg = 0;
    repeat (3) @(negedge clk);
    check(lineSym == 2'b00, "R1", "reset lineSym", int'(lineSym), 0);
    check(rxDv == 0 && rxEr == 0, "R1", "reset rx flags", int'({rxDv, rxEr}), 0);
    check(rxD == 0, "R1", "reset rxD", int'(rxD), 0);
    check(nibbleReq == 0, "R1", "reset nibbleReq", int'(nibbleReq), 0);
    rstN = 1;
    repeat (4) sendNib(0, 0, 4'h0);
    sendNib(0, 1, 4'hA);               // R3: error without frame
    sendNib(0, 1, 4'h3);
    // full frame over every nibble value (R2, R4, R5)
    repeat (7) sendNib(1, 0, 4'h5);
    sendNib(1, 0, 4'hD);
    for (int i = 0; i < 16; i++) sendNib(1, 0, 4'(i));
    repeat (5) sendNib(0, 0, 4'h0);
    // frame with error nibbles (R6)
    sendNib(1, 0, 4'h5); sendNib(1, 0, 4'h5);
    sendNib(1, 0, 4'h1); sendNib(1, 1, 4'h7); sendNib(1, 1, 4'h0);
    sendNib(1, 0, 4'h9); sendNib(1, 0, 4'hE);
    repeat (4) sendNib(0, 0, 4'h0);
    // one-nibble frame: K still follows J (R4, R5)
    sendNib(1, 0, 4'h5);
    repeat (5) sendNib(0, 0, 4'h0);
    // raw mode via pin with txEn toggling (R9, R11)
    modePin = 1;
    for (int i = 0; i < 14; i++) sendNib(i[0], i[1] ^ i[2], 4'((i * 7) + 3));
    sendNib(1, 0, 4'h0); sendNib(1, 1, 4'hF);
    modePin = 0;
    repeat (5) sendNib(0, 0, 4'h0);
    // raw mode via configuration bit (R9, R11)
    modeCfg = 1;
    for (int i = 0; i < 10; i++) sendNib(1, i[0], 4'(15 - i));
    modeCfg = 0;
    repeat (5) sendNib(0, 0, 4'h0);
    // normal frame after raw mode
    sendNib(1, 0, 4'h5); sendNib(1, 0, 4'h5);
    sendNib(1, 0, 4'hB); sendNib(1, 0, 4'h6); sendNib(1, 0, 4'h2);
    repeat (6) sendNib(0, 0, 4'h0);
    repeat (12) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule